// File: doc/BRIEF.md
# Four-Channel Hold-Shift Zero Suppressor

This block sits between a group of four time-digitizer channels and the write port of a level-one pipeline memory. Each channel offers a hit flag, four coarse-count bits and two fine-time bits. Once every four cycles of the block clock, the four channels are copied together into a hold register. During the next four cycles the held entries are presented one at a time, in channel order 0, 1, 2, 3. A slot with no hit produces no memory write. A slot with a hit writes one 9-bit word that carries the channel index and the timing bits.

A free-running marker timer inserts a timestamp word into the same stream every eight block-clock cycles. This lets readout logic relate stored hits to time. Hit words and marker words are told apart by the top bit. The write port accepts one word per cycle. When a marker and a hit fall in the same cycle, the marker goes first and the hit waits in a one-entry holding slot. The write address advances by one, modulo 512, on every word written.

Because capture happens only once every four cycles, hits on one channel must be at least four clock cycles apart. The memory and the readout logic are outside this block.

Top module: `hs_zero_supp`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en` is 0 and `wr_addr` is 0.
- R2: Channel inputs are sampled only at the clock edge where the internal phase count (0 at reset, +1 per cycle, modulo 4) equals 3. Input activity at any other edge never produces a hit word.
- R3: Slots captured together are offered in the four following cycles in channel order 0, 1, 2, 3. The resulting hit words appear in that order.
- R4: A slot whose hit flag is 0 produces no write, and so does a cycle with no marker due and nothing pending.
- R5: A hit word has bit 8 = 0, bits 7:6 = channel index, bits 5:2 = coarse count, and bits 1:0 = fine bits.
- R6: A marker word is written every 8 cycles, at the edges with cycle index 7, 15, 23, ... counted from reset release. It has bit 8 = 1 and bits 7:0 = the marker sequence number modulo 256, starting at 0.
- R7: When a marker is due in the same cycle as an offered hit, the marker is written and the hit goes into the holding slot. A held hit is written in the next cycle without a marker. Any hit offered in that cycle then takes the slot's place.
- R8: If a hit is offered while a marker is due and the holding slot is already full, the new hit is discarded and the held hit is kept.
- R9: The first write after reset uses address 0. Each later write uses the previous write address plus 1, modulo 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (106 MHz class) |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_vld | input | 4 | Hit flag per channel |
| hit_cc | input | 16 | Coarse-count bits, 4 per channel, channel 0 in bits 3:0 |
| hit_fine | input | 8 | Fine bits, 2 per channel, channel 0 in bits 1:0 |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 9 | Memory write address |
| wr_data | output | 9 | Memory write word (hit or marker) |

## Verification
The assertions check on every cycle the following:
- A due marker always takes the write port.
- A hit that collides with a marker lands in the holding slot unchanged.
- A discarded hit leaves the slot's contents intact.
- Idle cycles write nothing.
- Addresses step by exactly one.
- Markers are exactly eight cycles apart.

Only the bench's scenarios can show that the full word stream carries the right fields and the right channel order, and that off-phase input pulses are ignored. They also show that saturating traffic drops exactly the hits the holding rule predicts, and that the address wraps cleanly past 511.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MARK = 2'd1,
    SRC_PEND = 2'd2,
    SRC_CAND = 2'd3
  } wr_src_e;

  // Write-port priority: marker, then held hit, then the live slot.
  function automatic wr_src_e pick_source(input logic mark_due,
                                          input logic pend_full,
                                          input logic cand_vld);
    if (mark_due)       return SRC_MARK;
    else if (pend_full) return SRC_PEND;
    else if (cand_vld)  return SRC_CAND;
    else                return SRC_NONE;
  endfunction

endpackage

// File: rtl/hs_phase_timer.sv
module hs_phase_timer #(
  parameter int NCH         = 4,
  parameter int MARK_PERIOD = 8,
  parameter int TS_W        = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [$clog2(NCH)-1:0] slot,
  output logic                   load,
  output logic                   mark_due,
  output logic [TS_W-1:0]        mark_seq
);
  localparam int PH_W = $clog2(NCH);
  localparam int MT_W = $clog2(MARK_PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NCH - 1);
  localparam logic [MT_W-1:0] MT_LAST = MT_W'(MARK_PERIOD - 1);

  logic [PH_W-1:0] ph_q;
  logic [MT_W-1:0] mt_q;
  logic [TS_W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      mt_q  <= '0;
      seq_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
      mt_q <= (mt_q == MT_LAST) ? '0 : mt_q + 1'b1;
      if (mt_q == MT_LAST) seq_q <= seq_q + 1'b1;
    end
  end

  assign slot     = ph_q;
  assign load     = (ph_q == PH_LAST);
  assign mark_due = (mt_q == MT_LAST);
  assign mark_seq = seq_q;

  // R2: a new group always starts at slot 0 right after a capture
  p_load_then_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (slot == '0));
endmodule

// File: rtl/hs_hold_shift.sv
module hs_hold_shift #(
  parameter int NCH    = 4,
  parameter int CC_W   = 4,
  parameter int FINE_W = 2,
  parameter int DW     = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [$clog2(NCH)-1:0]  slot,
  input  logic [NCH-1:0]          in_vld,
  input  logic [NCH*CC_W-1:0]     in_cc,
  input  logic [NCH*FINE_W-1:0]   in_fine,
  output logic                    cand_vld,
  output logic [DW-1:0]           cand_word
);
  logic              hv_q [NCH];
  logic [CC_W-1:0]   hc_q [NCH];
  logic [FINE_W-1:0] hf_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hv_q[g] <= 1'b0;
        hc_q[g] <= '0;
        hf_q[g] <= '0;
      end else if (load) begin
        hv_q[g] <= in_vld[g];
        hc_q[g] <= in_cc[g*CC_W +: CC_W];
        hf_q[g] <= in_fine[g*FINE_W +: FINE_W];
      end
    end
  end

  assign cand_vld  = hv_q[slot];
  assign cand_word = {1'b0, slot, hc_q[slot], hf_q[slot]};
endmodule

// File: rtl/hs_write_arb.sv
module hs_write_arb
  import hs_pkg::*;
#(
  parameter int DW     = 9,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_due,
  input  logic [DW-1:0]     mark_word,
  input  logic              cand_vld,
  input  logic [DW-1:0]     cand_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              drop,
  output logic              pend_full
);
  wr_src_e           src;
  logic [DW-1:0]     pend_word;
  logic [DW-1:0]     sel_word;
  logic [ADDR_W-1:0] ptr_q;

  assign src  = pick_source(mark_due, pend_full, cand_vld);
  assign drop = mark_due && pend_full && cand_vld;

  always_comb begin
    unique case (src)
      SRC_MARK: sel_word = mark_word;
      SRC_PEND: sel_word = pend_word;
      SRC_CAND: sel_word = cand_word;
      default:  sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_word <= '0;
    end else begin
      unique case (src)
        SRC_MARK: if (cand_vld && !pend_full) begin
          pend_full <= 1'b1;
          pend_word <= cand_word;
        end
        SRC_PEND: begin
          pend_full <= cand_vld;
          if (cand_vld) pend_word <= cand_word;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ptr_q   <= '0;
    end else begin
      wr_en <= (src != SRC_NONE);
      if (src != SRC_NONE) begin
        wr_addr <= ptr_q;
        wr_data <= sel_word;
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  p_marker_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mark_due |=> (wr_en && wr_data[DW-1]));
  p_hit_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_due && cand_vld && !pend_full) |=> (pend_full && pend_word == $past(cand_word)));
  p_drop_keeps_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (pend_full && $stable(pend_word)));
  p_idle_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark_due && !pend_full && !cand_vld) |=> !wr_en);
endmodule

// File: rtl/hs_zero_supp.sv
module hs_zero_supp #(
  parameter int NCH         = 4,
  parameter int CC_W        = 4,
  parameter int FINE_W      = 2,
  parameter int ADDR_W      = 9,
  parameter int MARK_PERIOD = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCH-1:0]                 hit_vld,
  input  logic [NCH*CC_W-1:0]            hit_cc,
  input  logic [NCH*FINE_W-1:0]          hit_fine,
  output logic                           wr_en,
  output logic [ADDR_W-1:0]              wr_addr,
  output logic [$clog2(NCH)+CC_W+FINE_W:0] wr_data
);
  localparam int CH_W  = $clog2(NCH);
  localparam int DW    = 1 + CH_W + CC_W + FINE_W;
  localparam int TS_W  = DW - 1;
  localparam int GAP_W = $clog2(MARK_PERIOD) + 1;

  logic [CH_W-1:0] slot;
  logic            load;
  logic            mark_due;
  logic [TS_W-1:0] mark_seq;
  logic            cand_vld;
  logic [DW-1:0]   cand_word;
  logic            drop;
  logic            pend_full;

  hs_phase_timer #(.NCH(NCH), .MARK_PERIOD(MARK_PERIOD), .TS_W(TS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .load(load),
    .mark_due(mark_due), .mark_seq(mark_seq)
  );

  hs_hold_shift #(.NCH(NCH), .CC_W(CC_W), .FINE_W(FINE_W), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .slot(slot),
    .in_vld(hit_vld), .in_cc(hit_cc), .in_fine(hit_fine),
    .cand_vld(cand_vld), .cand_word(cand_word)
  );

  hs_write_arb #(.DW(DW), .ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .mark_due(mark_due), .mark_word({1'b1, mark_seq}),
    .cand_vld(cand_vld), .cand_word(cand_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .drop(drop), .pend_full(pend_full)
  );

  // Checker state: marker spacing and address stepping seen at the ports.
  logic              mark_out;
  logic [GAP_W-1:0]  gap_q;
  logic              seen_q;
  logic [ADDR_W-1:0] last_addr_q;

  assign mark_out = wr_en && wr_data[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q       <= '0;
      seen_q      <= 1'b0;
      last_addr_q <= '0;
    end else begin
      gap_q <= mark_out ? GAP_W'(1) : gap_q + 1'b1;
      if (wr_en) begin
        seen_q      <= 1'b1;
        last_addr_q <= wr_addr;
      end
    end
  end

  p_mark_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_out |-> (gap_q == GAP_W'(MARK_PERIOD)));
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seen_q) |-> (wr_addr == last_addr_q + 1'b1));
  p_addr_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !seen_q) |-> (wr_addr == '0));
endmodule

// File: tb/test_hs_zero_supp.sv
module test_hs_zero_supp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hit_vld = '0;
  logic [15:0] hit_cc = '0;
  logic [7:0] hit_fine = '0;
  logic       wr_en;
  logic [8:0] wr_addr;
  logic [8:0] wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  hs_zero_supp i_hs_zero_supp (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_cc(hit_cc),
    .hit_fine(hit_fine), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Reference state, written from the requirements
  logic       m_hv [4];
  logic [3:0] m_hc [4];
  logic [1:0] m_hf [4];
  logic       m_pf;
  logic [8:0] m_pw;
  logic [7:0] m_seq;
  logic [8:0] m_ptr;
  logic       e_en;
  logic [8:0] e_data, e_addr;
  int drops = 0, collisions = 0, held_writes = 0;
  int offphase_hits = 0, last_mark = -1, mark_gap_bad = 0, total_writes = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] hit_word(input int ch, input logic [3:0] cc, input logic [1:0] f);
    return {1'b0, 2'(ch), cc, f};   // R5 layout
  endfunction

  // One clock edge of the reference, edge index n since reset release
  task automatic model_step(input int n);
    int ph = n % 4;
    bit due = (n % 8) == 7;
    bit cv = m_hv[ph];
    logic [8:0] cw = hit_word(ph, m_hc[ph], m_hf[ph]);
    e_en = 1'b0;
    if (due) begin
      e_en = 1'b1; e_data = {1'b1, m_seq}; m_seq++;
      if (cv) begin
        collisions++;
        if (m_pf) drops++;
        else begin m_pf = 1'b1; m_pw = cw; end
      end
    end else if (m_pf) begin
      e_en = 1'b1; e_data = m_pw; held_writes++;
      m_pf = cv; if (cv) m_pw = cw;
    end else if (cv) begin
      e_en = 1'b1; e_data = cw;
    end
    if (e_en) begin e_addr = m_ptr; m_ptr++; end
    if (ph == 3) begin
      for (int c = 0; c < 4; c++) begin
        m_hv[c] = hit_vld[c];
        m_hc[c] = hit_cc[c*4 +: 4];
        m_hf[c] = hit_fine[c*2 +: 2];
      end
    end
  endtask

  task automatic compare(input int n, input bit in_r2_window);
    string tag;
    if (wr_en && !wr_data[8] && in_r2_window) offphase_hits++;
    if (wr_en) total_writes++;
    if (wr_en && wr_data[8]) begin
      if (last_mark >= 0 && n - last_mark != 8) mark_gap_bad++;
      last_mark = n;
    end
    if (!e_en) begin
      check(!wr_en, "R4 unexpected write", int'(wr_en), 0);
    end else begin
      tag = e_data[8] ? "R6 marker word" : "R3 R5 R7 hit word";
      check(wr_en && wr_data == e_data, tag, int'({wr_en, wr_data}), int'({1'b1, e_data}));
      check(wr_addr == e_addr, "R9 address", int'(wr_addr), int'(e_addr));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0417));
    for (int c = 0; c < 4; c++) begin m_hv[c] = 0; m_hc[c] = 0; m_hf[c] = 0; end
    m_pf = 0; m_pw = 0; m_seq = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
    check(wr_addr == 9'd0, "R1 wr_addr in reset", int'(wr_addr), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 2400; n++) begin
      if (n < 64) begin
        hit_vld = '0; hit_cc = '0; hit_fine = '0;
      end else if (n < 128) begin
        // R2: activity only at edges that do not capture
        hit_vld  = ((n % 4) == 3) ? 4'h0 : 4'hf;
        hit_cc   = 16'($urandom);
        hit_fine = 8'($urandom);
      end else if (n < 256) begin
        hit_vld  = 4'hf;
        hit_cc   = 16'($urandom);
        hit_fine = 8'($urandom);
      end else begin
        hit_vld  = 4'($urandom & $urandom);
        hit_cc   = 16'($urandom);
        hit_fine = 8'($urandom);
      end
      model_step(n);
      @(negedge clk);
      if (n == 0) check(!wr_en, "R1 first cycle after reset", int'(wr_en), 0);
      compare(n, n >= 68 && n < 132);
    end
    check(offphase_hits == 0, "R2 off-phase inputs wrote hits", offphase_hits, 0);
    check(mark_gap_bad == 0, "R6 marker spacing", mark_gap_bad, 0);
    check(collisions > 0 && held_writes > 0, "R7 collision scenario reached", collisions, 1);
    check(drops > 0, "R8 drop scenario reached", drops, 1);
    check(total_writes > 512, "R9 address wrap reached", total_writes, 513);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule